// File: doc/BRIEF.md
# Unified Register Rename Table

This block is the register rename table of an out-of-order core. A single flattened architectural register index selects one of three register classes: integer, floating point or miscellaneous. The index is split into a class and an index within that class. Integer and floating-point registers each have their own mapping table and their own free list of physical registers. Miscellaneous registers are never renamed. They translate to a fixed physical index placed above every real physical register.

The table does three things. A lookup returns the current mapping combinationally. A rename takes the oldest free physical register of the addressed class. It reports that register and the mapping it replaces, and the table takes the new mapping at the next clock edge. An entry write forces a mapping directly and is used to roll mappings back after a squash. A release input returns physical registers to the free list of their class. The block reports free capacity as the smaller of the two free-list counts, so the reported number of renames can be granted whichever class they target.

Each free list has a small state machine with two states. FL_FILL is entered at reset and pushes the physical registers that the reset mapping leaves unused, one per cycle, in ascending order. After the last preload push it takes the transition FILL_DONE to FL_RUN. FL_RUN serves the pops requested by renames and the pushes requested by releases. It stays in FL_RUN until the next reset. `ready_o` is high once both lists are in FL_RUN.

Top module: `rn_unified_map`

## Requirements
- R1: Unified indices 0..7 are integer, 8..15 are floating point, 16..19 are miscellaneous, and 20..31 address no class. After reset, integer register i maps to physical i and floating-point register i maps to physical 16+i. `ready_o` is low right after reset and high after 8 clock edges. At that point each free list holds the unused physical registers of its class (integer 8..15, floating point 24..31) in ascending order, and `free_count_o` is 8.
- R2: A rename of a non-zero integer or floating-point register that can be served behaves as follows:
  - It raises `rn_done_o` in the same cycle.
  - `rn_new_o` is the oldest entry of that class's free list and `rn_prev_o` is the current mapping.
  - From the next edge, a lookup of that register returns `rn_new_o` and that class's free count is one lower.
- R3: The integer register at relative index 0 is a zero register. A rename of it is ignored: `rn_new_o` and `rn_prev_o` both equal its current mapping, and no free-list entry is used. The floating-point class has no zero register, so a rename of floating-point relative index 0 allocates normally.
- R4: A miscellaneous register with relative index m maps to physical 32+m, both in lookups and in renames. A rename of it reports `rn_prev_o` equal to `rn_new_o` and raises `rn_done_o`. It never stalls and uses no free-list entry.
- R5: A rename that needs a free register raises `rn_stall_o` and keeps `rn_done_o` low in either of two cases: its class free list is empty, or that list is still preloading. A stalled rename changes no mapping and no count.
- R6: An entry write sets the mapping from the next edge and leaves the free lists unchanged. The write is ignored in three cases:
  - its physical index lies outside the range of the addressed class (integer 0..15, floating point 16..31);
  - it addresses a miscellaneous register;
  - it addresses an index that belongs to no class.
- R7: When a rename and an accepted entry write address the same register in one cycle, the mapping takes the written value. The rename is still served: it reports its outputs and consumes its free-list entry.
- R8: A lookup is combinational. It returns the mapping as it stood before the current edge and changes no state. An index that belongs to no class returns 0.
- R9: `free_count_o` equals the smaller of the integer and floating-point free-list counts.
- R10: A release pushes its physical index onto the free list of the class whose range contains it. A pushed register is handed out only after the entries already queued. A release with an index of 32 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_arch_i | input | 2x5 | Unified architectural index for each lookup port |
| lk_phys_o | output | 2x6 | Physical index for each lookup port |
| rn_valid_i | input | 1 | Rename request |
| rn_arch_i | input | 5 | Unified architectural index to rename |
| rn_done_o | output | 1 | Rename served this cycle |
| rn_stall_o | output | 1 | Rename refused this cycle |
| rn_new_o | output | 6 | Newly assigned physical index |
| rn_prev_o | output | 6 | Physical index mapped before the rename |
| wr_valid_i | input | 1 | Entry write request |
| wr_arch_i | input | 5 | Unified architectural index to overwrite |
| wr_phys_i | input | 6 | Physical index to store |
| fr_valid_i | input | 1 | Release request |
| fr_phys_i | input | 6 | Physical index returned to its free list |
| free_count_o | output | 5 | Smaller of the two free-list counts |
| ready_o | output | 1 | Both free lists have finished preloading |

## Verification
A corrupted map entry shows up on the lookup ports in the cycle after the faulty update, and on `rn_prev_o` at the next rename of that register. A corrupted free-list pointer or count shows up within one rename. It appears as a wrong `rn_new_o`, a wrong step in `free_count_o`, or a stall that comes too early or too late. The sweeps compare every unified index against an arithmetic model after reset and again at the end. Between those sweeps they drive each class through exhaustion, release, zero-register, miscellaneous and same-cycle conflict cases, so most faults surface within a few cycles of their cause.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [1:0] {
        RC_INT  = 2'd0,
        RC_FP   = 2'd1,
        RC_MISC = 2'd2,
        RC_NONE = 2'd3
    } reg_class_e;

    typedef enum logic {
        FL_FILL = 1'b0,
        FL_RUN  = 1'b1
    } fl_state_e;

endpackage

// File: rtl/rn_decode.sv
module rn_decode
    import rn_pkg::*;
#(
    parameter int NIA = 8,
    parameter int NFA = 8,
    parameter int NMA = 4,
    parameter int AW  = 5,
    parameter int RAW = 3
) (
    input  logic [AW-1:0]  arch_i,
    output reg_class_e     cls_o,
    output logic [RAW-1:0] rel_o
);

    localparam int FP_LO   = NIA;
    localparam int MISC_LO = NIA + NFA;
    localparam int LIMIT   = NIA + NFA + NMA;

    always_comb begin
        int a;
        a = int'(arch_i);
        if (a < FP_LO) begin
            cls_o = RC_INT;
            rel_o = RAW'(a);
        end else if (a < MISC_LO) begin
            cls_o = RC_FP;
            rel_o = RAW'(a - FP_LO);
        end else if (a < LIMIT) begin
            cls_o = RC_MISC;
            rel_o = RAW'(a - MISC_LO);
        end else begin
            cls_o = RC_NONE;
            rel_o = '0;
        end
    end

endmodule

// File: rtl/rn_class_map.sv
module rn_class_map #(
    parameter int NA     = 8,
    parameter int RAW    = 3,
    parameter int PW     = 6,
    parameter int BASE   = 0,
    parameter int NUM_RD = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_RD-1:0][RAW-1:0]   rd_rel_i,
    output logic [NUM_RD-1:0][PW-1:0]    rd_phys_o,
    input  logic [RAW-1:0]               rn_rel_i,
    output logic [PW-1:0]                rn_prev_o,
    input  logic                         upd_rn_i,
    input  logic [PW-1:0]                rn_phys_i,
    input  logic                         upd_wr_i,
    input  logic [RAW-1:0]               wr_rel_i,
    input  logic [PW-1:0]                wr_phys_i
);

    localparam int MW = (NA > 1) ? $clog2(NA) : 1;

    logic [PW-1:0] map_q [NA];

    // Read ports see the table as it stood before the edge.
    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
        assign rd_phys_o[k] = map_q[MW'(rd_rel_i[k])];
    end

    assign rn_prev_o = map_q[MW'(rn_rel_i)];

    // The entry write outranks a rename aimed at the same register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NA; i++) begin
                map_q[i] <= PW'(BASE + i);
            end
        end else begin
            for (int i = 0; i < NA; i++) begin
                if (upd_wr_i && (int'(wr_rel_i) == i)) begin
                    map_q[i] <= wr_phys_i;
                end else if (upd_rn_i && (int'(rn_rel_i) == i)) begin
                    map_q[i] <= rn_phys_i;
                end
            end
        end
    end

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PW        = 6,
    parameter int CW        = 5,
    parameter int FILL_BASE = 8,
    parameter int FILL_NUM  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [PW-1:0] push_phys_i,
    input  logic          pop_i,
    output logic [PW-1:0] head_o,
    output logic [CW-1:0] count_o,
    output logic          ready_o
);

    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam fl_state_e RESET_STATE = (FILL_NUM == 0) ? FL_RUN : FL_FILL;

    fl_state_e       state_q, state_d;
    logic [CW-1:0]   fill_q;
    logic [CW-1:0]   count_q;
    logic [PTRW-1:0] rd_ptr_q, wr_ptr_q;
    logic [PW-1:0]   slot_q [DEPTH];

    logic            do_push, do_pop;
    logic [PW-1:0]   push_val;

    function automatic logic [PTRW-1:0] ptr_next(input logic [PTRW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PTRW'(1);
    endfunction

    // State register and preload counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FL_FILL) begin
                fill_q <= fill_q + CW'(1);
            end
        end
    end

    // Next-state logic: FILL_DONE after the last preload push.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_FILL: if (int'(fill_q) == FILL_NUM - 1) state_d = FL_RUN;
            FL_RUN:  state_d = FL_RUN;
        endcase
    end

    // Outputs of the state machine: which push and pop take effect.
    always_comb begin
        unique case (state_q)
            FL_FILL: begin
                do_push  = 1'b1;
                push_val = PW'(FILL_BASE + int'(fill_q));
                do_pop   = 1'b0;
                ready_o  = 1'b0;
            end
            FL_RUN: begin
                do_push  = push_i && (int'(count_q) < DEPTH);
                push_val = push_phys_i;
                do_pop   = pop_i && (count_q != '0);
                ready_o  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_q[wr_ptr_q] <= push_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head_o  = slot_q[rd_ptr_q];
    assign count_o = count_q;

endmodule

// File: rtl/rn_unified_map.sv
module rn_unified_map
    import rn_pkg::*;
#(
    parameter int NIA      = 8,
    parameter int NFA      = 8,
    parameter int NMA      = 4,
    parameter int NIP      = 16,
    parameter int NFP      = 16,
    parameter int INT_ZERO = 0,
    parameter int FP_ZERO  = NFA,
    parameter int NUM_RD   = 2,
    parameter int AW       = $clog2(NIA + NFA + NMA),
    parameter int PW       = $clog2(NIP + NFP + NMA),
    parameter int CW       = $clog2(((NIP > NFP) ? NIP : NFP) + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_RD-1:0][AW-1:0]  lk_arch_i,
    output logic [NUM_RD-1:0][PW-1:0]  lk_phys_o,
    input  logic                       rn_valid_i,
    input  logic [AW-1:0]              rn_arch_i,
    output logic                       rn_done_o,
    output logic                       rn_stall_o,
    output logic [PW-1:0]              rn_new_o,
    output logic [PW-1:0]              rn_prev_o,
    input  logic                       wr_valid_i,
    input  logic [AW-1:0]              wr_arch_i,
    input  logic [PW-1:0]              wr_phys_i,
    input  logic                       fr_valid_i,
    input  logic [PW-1:0]              fr_phys_i,
    output logic [CW-1:0]              free_count_o,
    output logic                       ready_o
);

    localparam int TOTAL = NIP + NFP;
    localparam int MAXA  = (NIA > NFA) ? ((NIA > NMA) ? NIA : NMA)
                                       : ((NFA > NMA) ? NFA : NMA);
    localparam int RAW   = (MAXA > 1) ? $clog2(MAXA) : 1;

    function automatic logic [PW-1:0] misc_phys(input logic [RAW-1:0] rel);
        return PW'(TOTAL + int'(rel));
    endfunction

    function automatic logic in_int(input logic [PW-1:0] p);
        return int'(p) < NIP;
    endfunction

    function automatic logic in_fp(input logic [PW-1:0] p);
        return (int'(p) >= NIP) && (int'(p) < TOTAL);
    endfunction

    // Class decoding for every request port.
    reg_class_e            rn_cls, wr_cls;
    logic [RAW-1:0]        rn_rel, wr_rel;
    reg_class_e            lk_cls [NUM_RD];
    logic [NUM_RD-1:0][RAW-1:0] lk_rel;

    rn_decode #(.NIA(NIA), .NFA(NFA), .NMA(NMA), .AW(AW), .RAW(RAW)) u_dec_rn (
        .arch_i(rn_arch_i), .cls_o(rn_cls), .rel_o(rn_rel)
    );

    rn_decode #(.NIA(NIA), .NFA(NFA), .NMA(NMA), .AW(AW), .RAW(RAW)) u_dec_wr (
        .arch_i(wr_arch_i), .cls_o(wr_cls), .rel_o(wr_rel)
    );

    for (genvar k = 0; k < NUM_RD; k++) begin : g_lk_dec
        rn_decode #(.NIA(NIA), .NFA(NFA), .NMA(NMA), .AW(AW), .RAW(RAW)) u_dec_lk (
            .arch_i(lk_arch_i[k]), .cls_o(lk_cls[k]), .rel_o(lk_rel[k])
        );
    end

    // Free lists.
    logic          int_push, fp_push, int_pop, fp_pop;
    logic [PW-1:0] int_head, fp_head;
    logic [CW-1:0] int_cnt, fp_cnt;
    logic          int_ready, fp_ready;

    rn_free_list #(
        .DEPTH(NIP), .PW(PW), .CW(CW), .FILL_BASE(NIA), .FILL_NUM(NIP - NIA)
    ) u_int_free (
        .clk(clk), .rst_n(rst_n),
        .push_i(int_push), .push_phys_i(fr_phys_i), .pop_i(int_pop),
        .head_o(int_head), .count_o(int_cnt), .ready_o(int_ready)
    );

    rn_free_list #(
        .DEPTH(NFP), .PW(PW), .CW(CW), .FILL_BASE(NIP + NFA), .FILL_NUM(NFP - NFA)
    ) u_fp_free (
        .clk(clk), .rst_n(rst_n),
        .push_i(fp_push), .push_phys_i(fr_phys_i), .pop_i(fp_pop),
        .head_o(fp_head), .count_o(fp_cnt), .ready_o(fp_ready)
    );

    // Map tables.
    logic [NUM_RD-1:0][PW-1:0] int_rd, fp_rd;
    logic [PW-1:0] int_prev, fp_prev;
    logic          int_wr, fp_wr;

    rn_class_map #(
        .NA(NIA), .RAW(RAW), .PW(PW), .BASE(0), .NUM_RD(NUM_RD)
    ) u_int_map (
        .clk(clk), .rst_n(rst_n),
        .rd_rel_i(lk_rel), .rd_phys_o(int_rd),
        .rn_rel_i(rn_rel), .rn_prev_o(int_prev),
        .upd_rn_i(int_pop), .rn_phys_i(int_head),
        .upd_wr_i(int_wr), .wr_rel_i(wr_rel), .wr_phys_i(wr_phys_i)
    );

    rn_class_map #(
        .NA(NFA), .RAW(RAW), .PW(PW), .BASE(NIP), .NUM_RD(NUM_RD)
    ) u_fp_map (
        .clk(clk), .rst_n(rst_n),
        .rd_rel_i(lk_rel), .rd_phys_o(fp_rd),
        .rn_rel_i(rn_rel), .rn_prev_o(fp_prev),
        .upd_rn_i(fp_pop), .rn_phys_i(fp_head),
        .upd_wr_i(fp_wr), .wr_rel_i(wr_rel), .wr_phys_i(wr_phys_i)
    );

    // Rename control.
    logic rn_zero, alloc_int, alloc_fp;

    always_comb begin
        rn_zero   = ((rn_cls == RC_INT) && (int'(rn_rel) == INT_ZERO)) ||
                    ((rn_cls == RC_FP)  && (int'(rn_rel) == FP_ZERO));
        alloc_int = rn_valid_i && (rn_cls == RC_INT) && !rn_zero;
        alloc_fp  = rn_valid_i && (rn_cls == RC_FP)  && !rn_zero;

        rn_stall_o = (alloc_int && (!int_ready || (int_cnt == '0))) ||
                     (alloc_fp  && (!fp_ready  || (fp_cnt  == '0)));
        rn_done_o  = rn_valid_i && (rn_cls != RC_NONE) && !rn_stall_o;
        int_pop    = alloc_int && !rn_stall_o;
        fp_pop     = alloc_fp  && !rn_stall_o;

        unique case (rn_cls)
            RC_INT: begin
                rn_new_o  = rn_zero ? int_prev : int_head;
                rn_prev_o = int_prev;
            end
            RC_FP: begin
                rn_new_o  = rn_zero ? fp_prev : fp_head;
                rn_prev_o = fp_prev;
            end
            RC_MISC: begin
                rn_new_o  = misc_phys(rn_rel);
                rn_prev_o = misc_phys(rn_rel);
            end
            RC_NONE: begin
                rn_new_o  = '0;
                rn_prev_o = '0;
            end
        endcase
    end

    // Entry writes and releases, each filtered by class range.
    always_comb begin
        int_wr   = wr_valid_i && (wr_cls == RC_INT) && in_int(wr_phys_i);
        fp_wr    = wr_valid_i && (wr_cls == RC_FP)  && in_fp(wr_phys_i);
        int_push = fr_valid_i && in_int(fr_phys_i);
        fp_push  = fr_valid_i && in_fp(fr_phys_i);
    end

    // Lookup ports.
    for (genvar k = 0; k < NUM_RD; k++) begin : g_lk
        always_comb begin
            unique case (lk_cls[k])
                RC_INT:  lk_phys_o[k] = int_rd[k];
                RC_FP:   lk_phys_o[k] = fp_rd[k];
                RC_MISC: lk_phys_o[k] = misc_phys(lk_rel[k]);
                RC_NONE: lk_phys_o[k] = '0;
            endcase
        end
    end

    assign free_count_o = (int_cnt < fp_cnt) ? int_cnt : fp_cnt;
    assign ready_o      = int_ready && fp_ready;

endmodule

// File: rtl/rn_unified_map_chk.sv
module rn_unified_map_chk #(
    parameter int NIA      = 8,
    parameter int NFA      = 8,
    parameter int NMA      = 4,
    parameter int NIP      = 16,
    parameter int NFP      = 16,
    parameter int INT_ZERO = 0,
    parameter int NUM_RD   = 2,
    parameter int AW       = 5,
    parameter int PW       = 6,
    parameter int CW       = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_RD-1:0][AW-1:0] lk_arch_i,
    input logic [NUM_RD-1:0][PW-1:0] lk_phys_o,
    input logic                      rn_valid_i,
    input logic [AW-1:0]             rn_arch_i,
    input logic                      rn_done_o,
    input logic                      rn_stall_o,
    input logic [PW-1:0]             rn_new_o,
    input logic [PW-1:0]             rn_prev_o,
    input logic                      wr_valid_i,
    input logic [AW-1:0]             wr_arch_i,
    input logic [PW-1:0]             wr_phys_i,
    input logic                      fr_valid_i,
    input logic [CW-1:0]             free_count_o,
    input logic                      ready_o
);

    localparam int MISC_LO = NIA + NFA;
    localparam int TOTAL   = NIP + NFP;

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic vis_rn, int_wr_ok, misc_rn, zero_rn;
    always_comb begin
        vis_rn    = rn_done_o && !(wr_valid_i && (wr_arch_i == rn_arch_i));
        int_wr_ok = wr_valid_i && (int'(wr_arch_i) < NIA) && (int'(wr_phys_i) < NIP);
        misc_rn   = rn_valid_i && (int'(rn_arch_i) >= MISC_LO) &&
                    (int'(rn_arch_i) < MISC_LO + NMA);
        zero_rn   = rn_valid_i && (INT_ZERO < NIA) && (int'(rn_arch_i) == INT_ZERO);
    end

    // R2: a served rename is visible on the lookup port one edge later.
    assert_rename_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(vis_rn) && (lk_arch_i[0] == $past(rn_arch_i))
        |-> lk_phys_o[0] == $past(rn_new_o));

    // R3: renaming the integer zero register reports its own mapping.
    assert_zero_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rn |-> (rn_new_o == rn_prev_o));

    // R3: renaming the integer zero register consumes no free entry.
    assert_zero_no_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(zero_rn) && $past(ready_o) && !$past(fr_valid_i)
        |-> free_count_o == $past(free_count_o));

    // R4: miscellaneous renames pass through above the physical range.
    assert_misc_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        misc_rn |-> (rn_new_o == rn_prev_o) && rn_done_o && !rn_stall_o &&
                    (int'(rn_new_o) == int'(rn_arch_i) - MISC_LO + TOTAL));

    // R5: a stalled rename leaves the free capacity unchanged.
    assert_stall_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(rn_stall_o) && $past(ready_o) && !$past(fr_valid_i)
        |-> free_count_o == $past(free_count_o));

    // R5: stall and done never coincide.
    assert_stall_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rn_stall_o |-> !rn_done_o);

    // R6: an accepted integer entry write is visible one edge later.
    assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(int_wr_ok) && (lk_arch_i[NUM_RD-1] == $past(wr_arch_i))
        |-> lk_phys_o[NUM_RD-1] == $past(wr_phys_i));

    // R8: without updates a held lookup index gives a held result.
    assert_lookup_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(rn_done_o) && !$past(wr_valid_i) && $stable(lk_arch_i[0])
        |-> $stable(lk_phys_o[0]));

endmodule

bind rn_unified_map rn_unified_map_chk #(
    .NIA(NIA), .NFA(NFA), .NMA(NMA), .NIP(NIP), .NFP(NFP),
    .INT_ZERO(INT_ZERO), .NUM_RD(NUM_RD), .AW(AW), .PW(PW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lk_arch_i(lk_arch_i), .lk_phys_o(lk_phys_o),
    .rn_valid_i(rn_valid_i), .rn_arch_i(rn_arch_i),
    .rn_done_o(rn_done_o), .rn_stall_o(rn_stall_o),
    .rn_new_o(rn_new_o), .rn_prev_o(rn_prev_o),
    .wr_valid_i(wr_valid_i), .wr_arch_i(wr_arch_i), .wr_phys_i(wr_phys_i),
    .fr_valid_i(fr_valid_i),
    .free_count_o(free_count_o), .ready_o(ready_o)
);

// File: tb/rn_unified_map_bench.sv
module rn_unified_map_bench;

    localparam int NIA = 8, NFA = 8, NMA = 4, NIP = 16, NFP = 16;
    localparam int TOTAL = NIP + NFP;
    localparam int AW = 5, PW = 6, CW = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0][AW-1:0]  lk_arch = '0;
    logic [1:0][PW-1:0]  lk_phys;
    logic                rn_valid = 1'b0;
    logic [AW-1:0]       rn_arch = '0;
    logic                rn_done, rn_stall;
    logic [PW-1:0]       rn_new, rn_prev;
    logic                wr_valid = 1'b0;
    logic [AW-1:0]       wr_arch = '0;
    logic [PW-1:0]       wr_phys = '0;
    logic                fr_valid = 1'b0;
    logic [PW-1:0]       fr_phys = '0;
    logic [CW-1:0]       free_count;
    logic                ready;

    always #5 clk = ~clk;

    rn_unified_map u_rn_unified_map (
        .clk(clk), .rst_n(rst_n),
        .lk_arch_i(lk_arch), .lk_phys_o(lk_phys),
        .rn_valid_i(rn_valid), .rn_arch_i(rn_arch),
        .rn_done_o(rn_done), .rn_stall_o(rn_stall),
        .rn_new_o(rn_new), .rn_prev_o(rn_prev),
        .wr_valid_i(wr_valid), .wr_arch_i(wr_arch), .wr_phys_i(wr_phys),
        .fr_valid_i(fr_valid), .fr_phys_i(fr_phys),
        .free_count_o(free_count), .ready_o(ready)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int exp_map [NIA+NFA];
    int int_q [$];
    int fp_q [$];

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lookup(input int a);
        if (a < NIA + NFA)            return exp_map[a];
        else if (a < NIA + NFA + NMA) return TOTAL + a - (NIA + NFA);
        else                          return 0;
    endfunction

    function automatic int exp_min();
        return (int_q.size() < fp_q.size()) ? int_q.size() : fp_q.size();
    endfunction

    task automatic lookup_check(input int a, input string tag);
        @(negedge clk);
        lk_arch[0] = AW'(a);
        lk_arch[1] = AW'(a);
        #1;
        chk(tag, int'(lk_phys[0]), exp_lookup(a));
        chk(tag, int'(lk_phys[1]), exp_lookup(a));
    endtask

    task automatic count_check(input string tag);
        @(negedge clk);
        chk(tag, int'(free_count), exp_min());
    endtask

    // One rename with expectations from the class rules.
    task automatic rename_op(input int a, input string tag);
        int  e_new, e_prev, cls;
        bit  e_stall, alloc;
        @(negedge clk);
        rn_valid = 1'b1;
        rn_arch  = AW'(a);
        #1;
        e_stall = 1'b0;
        alloc   = 1'b0;
        cls = (a < NIA) ? 0 : (a < NIA + NFA) ? 1 : 2;
        if (cls == 2) begin
            e_new  = TOTAL + a - (NIA + NFA);
            e_prev = e_new;
        end else if (cls == 0 && a == 0) begin
            e_new  = exp_map[a];
            e_prev = exp_map[a];
        end else begin
            e_prev  = exp_map[a];
            e_stall = (cls == 0) ? (int_q.size() == 0) : (fp_q.size() == 0);
            alloc   = !e_stall;
            e_new   = e_stall ? 0 : ((cls == 0) ? int_q[0] : fp_q[0]);
        end
        chk({tag, " stall"}, int'(rn_stall), int'(e_stall));
        chk({tag, " done"}, int'(rn_done), int'(!e_stall));
        if (!e_stall) begin
            chk({tag, " new"}, int'(rn_new), e_new);
            chk({tag, " prev"}, int'(rn_prev), e_prev);
        end
        @(posedge clk);
        #1;
        rn_valid = 1'b0;
        if (alloc) begin
            if (cls == 0) void'(int_q.pop_front());
            else          void'(fp_q.pop_front());
            exp_map[a] = e_new;
        end
    endtask

    task automatic write_op(input int a, input int p);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_arch  = AW'(a);
        wr_phys  = PW'(p);
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        if (a < NIA && p < NIP) exp_map[a] = p;
        else if (a >= NIA && a < NIA + NFA && p >= NIP && p < TOTAL) exp_map[a] = p;
    endtask

    task automatic release_op(input int p);
        @(negedge clk);
        fr_valid = 1'b1;
        fr_phys  = PW'(p);
        @(posedge clk);
        #1;
        fr_valid = 1'b0;
        if (p < NIP)        int_q.push_back(p);
        else if (p < TOTAL) fp_q.push_back(p);
    endtask

    initial begin
        for (int i = 0; i < NIA; i++) exp_map[i] = i;
        for (int i = 0; i < NFA; i++) exp_map[NIA+i] = NIP + i;
        for (int i = NIA; i < NIP; i++) int_q.push_back(i);
        for (int i = NIP + NFA; i < TOTAL; i++) fp_q.push_back(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 ready low after reset", int'(ready), 0);
        rn_valid = 1'b1;
        rn_arch  = AW'(1);
        #1;
        chk("R5 stall while preloading", int'(rn_stall), 1);
        chk("R5 no done while preloading", int'(rn_done), 0);
        rn_valid = 1'b0;
        repeat (8) @(posedge clk);
        #1;
        chk("R1 ready after preload", int'(ready), 1);
        count_check("R1 R9 count after preload");

        // Sweep every unified index against the reset mapping.
        for (int a = 0; a < 32; a++) lookup_check(a, "R1 R4 R8 reset lookup");

        // Integer allocation in FIFO order until empty.
        for (int a = 1; a < NIA; a++) begin
            rename_op(a, "R2 int rename");
            lookup_check(a, "R2 int lookup after rename");
        end
        count_check("R2 R9 count after seven int renames");
        rename_op(1, "R2 int rename last entry");
        count_check("R9 min with empty int list");
        rename_op(2, "R5 int rename on empty list");
        lookup_check(2, "R5 mapping unchanged after stall");
        count_check("R5 count unchanged after stall");

        // Zero register and miscellaneous pass-through.
        rename_op(0, "R3 int zero rename");
        count_check("R3 zero rename takes no entry");
        lookup_check(0, "R3 zero mapping kept");
        for (int a = NIA + NFA; a < NIA + NFA + NMA; a++) rename_op(a, "R4 misc rename");
        count_check("R4 misc rename takes no entry");

        // Releases.
        release_op(3);
        count_check("R10 R9 int release counted");
        release_op(33);
        release_op(40);
        count_check("R10 out-of-range release ignored");
        release_op(20);
        count_check("R9 fp release leaves min");
        rename_op(2, "R10 released register handed out");

        // Floating point: relative 0 is not a zero register.
        for (int a = NIA; a < NIA + NFA; a++) begin
            rename_op(a, "R2 R3 fp rename");
            lookup_check(a, "R2 fp lookup after rename");
        end
        rename_op(NIA + 1, "R10 fp released register after queue");

        // Entry writes.
        write_op(5, 2);
        lookup_check(5, "R6 int write applied");
        write_op(5, 20);
        lookup_check(5, "R6 int write with fp index ignored");
        write_op(NIA + 1, 4);
        lookup_check(NIA + 1, "R6 fp write with int index ignored");
        write_op(NIA + 1, 17);
        lookup_check(NIA + 1, "R6 fp write applied");
        write_op(NIA + NFA + 1, 3);
        lookup_check(NIA + NFA + 1, "R6 misc write ignored");
        write_op(25, 3);
        lookup_check(25, "R6 classless write ignored");
        count_check("R6 writes leave free lists");

        // Rename and write to the same register in one cycle.
        release_op(10);
        release_op(11);
        @(negedge clk);
        rn_valid = 1'b1;
        rn_arch  = AW'(6);
        wr_valid = 1'b1;
        wr_arch  = AW'(6);
        wr_phys  = PW'(1);
        #1;
        chk("R7 rename served with write", int'(rn_done), 1);
        chk("R7 rename new with write", int'(rn_new), int_q[0]);
        @(posedge clk);
        #1;
        rn_valid = 1'b0;
        wr_valid = 1'b0;
        void'(int_q.pop_front());
        exp_map[6] = 1;
        lookup_check(6, "R7 write wins over rename");
        count_check("R7 rename still consumed entry");
        rename_op(7, "R7 next int entry after conflict");

        for (int a = 0; a < 32; a++) lookup_check(a, "R8 final lookup sweep");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1: actual 0 expected 1 (run did not end)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule